// File: doc/BRIEF.md
# Source-Routing Frame Filter

This block watches a byte-serial receive stream and decides, for source-routed bridging, whether a frame should be copied or dropped. It reads the frame control byte, skips the destination address, takes the routing-information indicator from the top bit of the first source-address byte, and then decodes the two-byte routing control field and the route descriptors that follow it. A frame is ignored when it is a token or carries no routing information. Otherwise its routing type selects one of three programmed actions: drop it, accept it at once, or examine the route.

When the route is examined, the length in the control field is validated first. Each adjacent pair of 16-bit descriptors forms one hop (input ring, bridge, output ring). Every hop is compared with sixteen programmable triples, and the direction bit swaps the ring order. A specifically-routed frame is taken when any hop matches. An explorer frame is taken only if the bridge's own port ring does not already appear in its route. Each decision is a single-cycle pulse, and a failed examination also pulses an error strobe for that frame type.

Top module: `srf_filter`

## Requirements
- R1: A frame whose first byte (marked by `rx_sof`) is 8'h80 or 8'hC0 is a token and produces no output pulse for that frame.
- R2: When bit 7 of frame byte 7 (the routing-information indicator) is 0, the frame produces no output pulse.
- R3: Routing-type bits are bits 7:5 of frame byte 13. The pattern 0xx is a specifically-routed frame (type 0), 10x an all-routes explorer (type 1) and 11x a spanning-tree explorer (type 2).
- R4: `cfg_type_sel` holds a 2-bit action per type at bits [2t+1:2t]. The code 2'b10 pulses `accept_now`, 2'b01 examines the route, and 2'b00 or 2'b11 pulses `stop_rx` without an error strobe. The pulse comes one cycle after byte 13.
- R5: In examine mode, a length field (bits 4:0 of byte 13) that is zero, odd or greater than `cfg_max_len` pulses `stop_rx` and `err_inc[t]` one cycle after byte 13.
- R6: Bit 7 of byte 14 is the direction bit. When it is 0 a hop is (ring(i), bridge(i), ring(i+1)). When it is 1 the hop is (ring(i+1), bridge(i), ring(i)).
- R7: Descriptors start at byte 15. Each one is two bytes: ring bits 11:4 in the first byte, then ring bits 3:0 in bits 7:4 of the second byte and the bridge in bits 3:0 of that byte. A hop matches entry e when `cfg_entry_en[e]` is set and its input ring, bridge and output ring all equal the entry's fields.
- R8: A type-0 frame in examine mode pulses `route_match` one cycle after its last route byte (byte 12+length) if any hop matches. Otherwise it pulses `stop_rx` and `err_inc[0]`.
- R9: An explorer frame in examine mode pulses `route_match` at that point if no descriptor ring equals `cfg_port_ring`. Otherwise it pulses `stop_rx` and `err_inc[t]`. A route with zero descriptors is accepted for explorers and rejected for type 0.
- R10: Outputs are zero after reset. At most one of `route_match`, `accept_now` and `stop_rx` is high in any cycle, and each lasts one cycle. Cycles with `rx_valid` low are skipped.
- R11: A byte with `rx_sof` high restarts parsing at byte 0 from any state. An unfinished frame produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_sof | input | 1 | This byte is byte 0 of a frame |
| rx_data | input | 8 | Receive byte |
| cfg_type_sel | input | 6 | Per-type action codes |
| cfg_max_len | input | 5 | Largest accepted routing-field length in bytes |
| cfg_port_ring | input | 12 | Ring number of this bridge port |
| cfg_entry_en | input | 16 | Enable per stored triple |
| cfg_in_ring | input | 192 | Input ring of each triple, entry e at [12e+11:12e] |
| cfg_bridge | input | 64 | Bridge number of each triple, entry e at [4e+3:4e] |
| cfg_out_ring | input | 192 | Output ring of each triple, entry e at [12e+11:12e] |
| route_match | output | 1 | Pulse: route examined and accepted |
| accept_now | output | 1 | Pulse: frame type accepted without examination |
| stop_rx | output | 1 | Pulse: stop reception and drop the frame |
| err_inc | output | 3 | Pulse per frame type: increment that error counter |

## Verification
The assertions assume that configuration is held steady while a frame is being parsed and that `rx_sof` comes only with `rx_valid`. The stimulus changes settings only in idle gaps between frames and always raises `rx_sof` together with a valid byte. A behavioural model in the bench rebuilds each frame in a byte queue, predicts the pulse expected after every byte, and is compared with the outputs on every clock. Directed frames cover each type and action, bad lengths, both directions, disabled entries, routing loops for explorers, mid-frame restarts and bursts with valid gaps. A long randomized run then mixes settings and frame contents.

// File: rtl/srf_pkg.sv
// Shared constants, types and helpers for the source-routing frame filter.
// Assumes byte 0 is the frame control byte, the indicator bit sits in byte 7
// and the routing control field starts at byte 13.
package srf_pkg;
    localparam int RING_W  = 12;
    localparam int BN_W    = 4;
    localparam int LEN_W   = 5;
    localparam int CNT_W   = 4;
    localparam int RII_POS = 7;
    localparam int RCF_POS = 13;
    localparam int N_KIND  = 3;

    typedef enum logic [1:0] {
        KIND_SRF = 2'd0,
        KIND_ARE = 2'd1,
        KIND_STE = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        ACT_DROP   = 2'd0,
        ACT_CHECK  = 2'd1,
        ACT_ACCEPT = 2'd2,
        ACT_DROP_B = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_RCF1 = 2'd2,
        ST_RD   = 2'd3
    } st_e;

    typedef struct packed {
        logic              match;
        logic              accept;
        logic              stop;
        logic [N_KIND-1:0] err;
    } verdict_t;

    // Restricted and non-restricted token control bytes.
    function automatic logic is_token(input logic [7:0] fc);
        return (fc == 8'h80) || (fc == 8'hC0);
    endfunction

    // Routing-type bits to frame kind.
    function automatic kind_e rt_kind(input logic [2:0] rt);
        if (!rt[2])      return KIND_SRF;
        else if (!rt[1]) return KIND_ARE;
        else             return KIND_STE;
    endfunction

    // One-hot error strobe for a kind.
    function automatic logic [N_KIND-1:0] kind_strobe(input kind_e k);
        case (k)
            KIND_SRF: return 3'b001;
            KIND_ARE: return 3'b010;
            default:  return 3'b100;
        endcase
    endfunction
endpackage

// File: rtl/srf_hop_table.sv
// Compares one hop against every stored (input ring, bridge, output ring)
// triple in parallel. Purely combinational; disabled entries never hit.
// Assumes the probe fields are stable for the cycle in which probe_valid is high.
module srf_hop_table
    import srf_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic [ENTRIES*RING_W-1:0] tbl_in_ring,
    input  logic [ENTRIES*BN_W-1:0]   tbl_bridge,
    input  logic [ENTRIES*RING_W-1:0] tbl_out_ring,
    input  logic [ENTRIES-1:0]        tbl_en,
    input  logic                      probe_valid,
    input  logic [RING_W-1:0]         probe_in,
    input  logic [BN_W-1:0]           probe_bn,
    input  logic [RING_W-1:0]         probe_out,
    output logic                      probe_hit
);
    logic [ENTRIES-1:0] hit_vec;

    // One comparator per stored triple.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        assign hit_vec[e] = tbl_en[e]
                         && (tbl_in_ring[e*RING_W +: RING_W]  == probe_in)
                         && (tbl_bridge[e*BN_W +: BN_W]       == probe_bn)
                         && (tbl_out_ring[e*RING_W +: RING_W] == probe_out);
    end

    // Any enabled entry equal to the probe counts as a hit.
    assign probe_hit = probe_valid && (|hit_vec);
endmodule

// File: rtl/srf_rd_track.sv
// Assembles 16-bit route descriptors from descriptor bytes and presents the
// hop formed by the previous and the current descriptor, ordered by the
// direction bit. Assumes restart is raised before the first descriptor byte.
module srf_rd_track
    import srf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              rd_valid,
    input  logic [7:0]        rd_byte,
    input  logic              dir_rev,
    output logic              ring_valid,
    output logic [RING_W-1:0] ring_now,
    output logic              hop_valid,
    output logic [RING_W-1:0] hop_in,
    output logic [BN_W-1:0]   hop_bn,
    output logic [RING_W-1:0] hop_out
);
    logic              phase_lo_q;
    logic [7:0]        hi_q;
    logic [RING_W-1:0] prev_ring_q;
    logic [BN_W-1:0]   prev_bn_q;
    logic              have_prev_q;

    // Byte phase, high-byte holding register and previous descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_lo_q  <= 1'b0;
            hi_q        <= '0;
            prev_ring_q <= '0;
            prev_bn_q   <= '0;
            have_prev_q <= 1'b0;
        end else if (rd_valid) begin
            if (!phase_lo_q) begin
                hi_q       <= rd_byte;
                phase_lo_q <= 1'b1;
            end else begin
                phase_lo_q  <= 1'b0;
                prev_ring_q <= ring_now;
                prev_bn_q   <= rd_byte[BN_W-1:0];
                have_prev_q <= 1'b1;
            end
        end
    end

    // Current descriptor ring and the hop it closes with the previous one.
    always_comb begin
        ring_now   = {hi_q, rd_byte[7:4]};
        ring_valid = rd_valid && phase_lo_q;
        hop_valid  = ring_valid && have_prev_q;
        hop_bn     = prev_bn_q;
        hop_in     = dir_rev ? ring_now    : prev_ring_q;
        hop_out    = dir_rev ? prev_ring_q : ring_now;
    end

    AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !restart && !phase_lo_q) |=> phase_lo_q); // R7
endmodule

// File: rtl/srf_frame_fsm.sv
// Frame parser and decision logic. Counts header bytes, drops tokens and
// frames without routing information, applies the per-type action, checks
// the length field and concludes the route examination. Decisions are
// registered one-cycle pulses. Assumes configuration is steady within a frame.
module srf_frame_fsm
    import srf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_data,
    input  logic [5:0]        cfg_type_sel,
    input  logic [LEN_W-1:0]  cfg_max_len,
    input  logic [RING_W-1:0] cfg_port_ring,
    input  logic              hop_hit,
    input  logic              ring_valid,
    input  logic [RING_W-1:0] ring_now,
    output logic              trk_restart,
    output logic              trk_rd_valid,
    output logic              dir_rev,
    output verdict_t          verdict
);
    st_e              st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    kind_e            kind_q, kind_d;
    logic [LEN_W-1:0] rem_q, rem_d;
    logic             dir_q, dir_d;
    logic             hit_q, hit_d;
    logic             loop_q, loop_d;
    verdict_t         v_q, v_d;
    act_e             act;
    logic             len_bad;
    logic             loop_now;

    // Tracker controls, kept apart from the decision logic.
    assign trk_restart  = rx_valid && (rx_sof || st_q == ST_RCF1);
    assign trk_rd_valid = rx_valid && !rx_sof && (st_q == ST_RD);
    assign dir_rev      = dir_q;
    assign loop_now     = ring_valid && (ring_now == cfg_port_ring);

    // Action code selected by the routing type of the current byte.
    always_comb begin
        case (rt_kind(rx_data[7:5]))
            KIND_SRF: act = act_e'(cfg_type_sel[1:0]);
            KIND_ARE: act = act_e'(cfg_type_sel[3:2]);
            default:  act = act_e'(cfg_type_sel[5:4]);
        endcase
        len_bad = (rx_data[4:0] == '0) || rx_data[0] || (rx_data[4:0] > cfg_max_len);
    end

    // Next-state and verdict computation for each received byte.
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        kind_d = kind_q;
        rem_d  = rem_q;
        dir_d  = dir_q;
        hit_d  = hit_q;
        loop_d = loop_q;
        v_d    = '0;
        if (rx_valid && rx_sof) begin
            cnt_d  = CNT_W'(1);
            hit_d  = 1'b0;
            loop_d = 1'b0;
            st_d   = is_token(rx_data) ? ST_IDLE : ST_HDR;
        end else if (rx_valid) begin
            case (st_q)
                ST_HDR: begin
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_q == CNT_W'(RII_POS) && !rx_data[7]) begin
                        st_d = ST_IDLE;
                    end else if (cnt_q == CNT_W'(RCF_POS)) begin
                        kind_d = rt_kind(rx_data[7:5]);
                        rem_d  = rx_data[4:0];
                        st_d   = ST_IDLE;
                        case (act)
                            ACT_ACCEPT: v_d.accept = 1'b1;
                            ACT_CHECK: begin
                                if (len_bad) begin
                                    v_d.stop = 1'b1;
                                    v_d.err  = kind_strobe(rt_kind(rx_data[7:5]));
                                end else begin
                                    st_d = ST_RCF1;
                                end
                            end
                            default: v_d.stop = 1'b1;
                        endcase
                    end
                end
                ST_RCF1: begin
                    dir_d = rx_data[7];
                    rem_d = rem_q - LEN_W'(2);
                    if (rem_q == LEN_W'(2)) begin
                        st_d = ST_IDLE;
                        if (kind_q == KIND_SRF) begin
                            v_d.stop = 1'b1;
                            v_d.err  = kind_strobe(kind_q);
                        end else begin
                            v_d.match = 1'b1;
                        end
                    end else begin
                        st_d = ST_RD;
                    end
                end
                ST_RD: begin
                    rem_d  = rem_q - LEN_W'(1);
                    hit_d  = hit_q | hop_hit;
                    loop_d = loop_q | loop_now;
                    if (rem_q == LEN_W'(1)) begin
                        st_d = ST_IDLE;
                        if ((kind_q == KIND_SRF) ? hit_d : !loop_d) begin
                            v_d.match = 1'b1;
                        end else begin
                            v_d.stop = 1'b1;
                            v_d.err  = kind_strobe(kind_q);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // State and verdict registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            kind_q <= KIND_SRF;
            rem_q  <= '0;
            dir_q  <= 1'b0;
            hit_q  <= 1'b0;
            loop_q <= 1'b0;
            v_q    <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            kind_q <= kind_d;
            rem_q  <= rem_d;
            dir_q  <= dir_d;
            hit_q  <= hit_d;
            loop_q <= loop_d;
            v_q    <= v_d;
        end
    end

    assign verdict = v_q;

    AST_RD_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RD) |-> (rem_q != '0)); // R5
    AST_HIT_IN_RD: assert property (@(posedge clk) disable iff (!rst_n)
        hop_hit |-> (st_q == ST_RD)); // R7
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({v_q.match, v_q.accept, v_q.stop})); // R10
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (|v_q.err) |-> v_q.stop); // R9
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q.match || v_q.accept || v_q.stop) |=> !(v_q.match || v_q.accept || v_q.stop)); // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !(rx_valid && rx_sof)) |=> (st_q == ST_IDLE)); // R11
endmodule

// File: rtl/srf_filter.sv
// Top level of the source-routing frame filter. Connects the frame parser,
// the descriptor tracker and the triple table. Assumes rx_sof is only
// raised with rx_valid and that configuration changes only between frames.
module srf_filter
    import srf_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rx_valid,
    input  logic                      rx_sof,
    input  logic [7:0]                rx_data,
    input  logic [5:0]                cfg_type_sel,
    input  logic [LEN_W-1:0]          cfg_max_len,
    input  logic [RING_W-1:0]         cfg_port_ring,
    input  logic [ENTRIES-1:0]        cfg_entry_en,
    input  logic [ENTRIES*RING_W-1:0] cfg_in_ring,
    input  logic [ENTRIES*BN_W-1:0]   cfg_bridge,
    input  logic [ENTRIES*RING_W-1:0] cfg_out_ring,
    output logic                      route_match,
    output logic                      accept_now,
    output logic                      stop_rx,
    output logic [N_KIND-1:0]         err_inc
);
    logic              trk_restart;
    logic              trk_rd_valid;
    logic              dir_rev;
    logic              ring_valid;
    logic [RING_W-1:0] ring_now;
    logic              hop_valid;
    logic [RING_W-1:0] hop_in;
    logic [BN_W-1:0]   hop_bn;
    logic [RING_W-1:0] hop_out;
    logic              hop_hit;
    verdict_t          verdict;

    srf_frame_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_sof       (rx_sof),
        .rx_data      (rx_data),
        .cfg_type_sel (cfg_type_sel),
        .cfg_max_len  (cfg_max_len),
        .cfg_port_ring(cfg_port_ring),
        .hop_hit      (hop_hit),
        .ring_valid   (ring_valid),
        .ring_now     (ring_now),
        .trk_restart  (trk_restart),
        .trk_rd_valid (trk_rd_valid),
        .dir_rev      (dir_rev),
        .verdict      (verdict)
    );

    srf_rd_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (trk_restart),
        .rd_valid  (trk_rd_valid),
        .rd_byte   (rx_data),
        .dir_rev   (dir_rev),
        .ring_valid(ring_valid),
        .ring_now  (ring_now),
        .hop_valid (hop_valid),
        .hop_in    (hop_in),
        .hop_bn    (hop_bn),
        .hop_out   (hop_out)
    );

    srf_hop_table #(.ENTRIES(ENTRIES)) u_table (
        .tbl_in_ring (cfg_in_ring),
        .tbl_bridge  (cfg_bridge),
        .tbl_out_ring(cfg_out_ring),
        .tbl_en      (cfg_entry_en),
        .probe_valid (hop_valid),
        .probe_in    (hop_in),
        .probe_bn    (hop_bn),
        .probe_out   (hop_out),
        .probe_hit   (hop_hit)
    );

    // Registered verdict fields to the ports.
    assign route_match = verdict.match;
    assign accept_now  = verdict.accept;
    assign stop_rx     = verdict.stop;
    assign err_inc     = verdict.err;
endmodule

// File: tb/srf_filter_bench.sv
module srf_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic rx_sof = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic [5:0] sel = 6'b100101;
    logic [4:0] maxlen = 5'd18;
    logic [11:0] port_ring = 12'h0A1;
    logic [NE-1:0] en;
    logic [11:0] tin [NE];
    logic [3:0]  tbn [NE];
    logic [11:0] tout [NE];
    logic [NE*12-1:0] cfg_in_ring, cfg_out_ring;
    logic [NE*4-1:0]  cfg_bridge;
    logic route_match, accept_now, stop_rx;
    logic [2:0] err_inc;

    int checks = 0;
    int failed = 0;
    string cur_tag = "R10";
    logic [5:0] exp_code = 6'd0;
    logic [5:0] evt = 6'd0;
    bit in_frame = 0;
    logic [7:0] fq [$];
    logic [11:0] rd_ring [16];
    logic [3:0]  rd_br [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int e = 0; e < NE; e++) begin
            cfg_in_ring[e*12 +: 12] = tin[e];
            cfg_out_ring[e*12 +: 12] = tout[e];
            cfg_bridge[e*4 +: 4] = tbn[e];
        end
    end

    srf_filter u_srf_filter (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
        .cfg_type_sel(sel), .cfg_max_len(maxlen), .cfg_port_ring(port_ring),
        .cfg_entry_en(en), .cfg_in_ring(cfg_in_ring), .cfg_bridge(cfg_bridge),
        .cfg_out_ring(cfg_out_ring), .route_match(route_match), .accept_now(accept_now),
        .stop_rx(stop_rx), .err_inc(err_inc)
    );

    // Behavioural model: the pulse expected after the newest byte of the frame.
    function automatic logic [5:0] ref_eval();
        int n, lth, kind, act, nrd, rin, rout;
        logic [2:0] rt;
        bit dir, hit, loop, ok;
        int rg[$];
        int bq[$];
        n = fq.size();
        if (n == 0) return 6'd0;
        if (fq[0] == 8'h80 || fq[0] == 8'hC0) return 6'd0;
        if (n < 8) return 6'd0;
        if (fq[7][7] == 1'b0) return 6'd0;
        if (n < 14) return 6'd0;
        rt = fq[13][7:5];
        lth = int'(fq[13][4:0]);
        kind = (rt[2] == 1'b0) ? 0 : ((rt[1] == 1'b0) ? 1 : 2);
        act = (int'(sel) >> (2*kind)) & 3;
        if (n == 14) begin
            if (act == 2) return 6'b010000;
            if (act != 1) return 6'b001000;
            if (lth == 0 || (lth % 2) == 1 || lth > int'(maxlen))
                return 6'b001000 | (6'd1 << kind);
            return 6'd0;
        end
        if (act != 1 || lth == 0 || (lth % 2) == 1 || lth > int'(maxlen)) return 6'd0;
        if (n - 1 != 12 + lth) return 6'd0;
        dir = fq[14][7];
        nrd = (lth - 2) / 2;
        for (int i = 0; i < nrd; i++) begin
            rg.push_back(int'({fq[15+2*i], fq[16+2*i][7:4]}));
            bq.push_back(int'(fq[16+2*i][3:0]));
        end
        hit = 0;
        loop = 0;
        for (int i = 0; i < nrd; i++) if (rg[i] == int'(port_ring)) loop = 1;
        for (int i = 0; i + 1 < nrd; i++) begin
            rin = dir ? rg[i+1] : rg[i];
            rout = dir ? rg[i] : rg[i+1];
            for (int e = 0; e < NE; e++)
                if (en[e] && int'(tin[e]) == rin && int'(tbn[e]) == bq[i] && int'(tout[e]) == rout)
                    hit = 1;
        end
        ok = (kind == 0) ? hit : !loop;
        return ok ? 6'b100000 : (6'b001000 | (6'd1 << kind));
    endfunction

    task automatic check_outputs();
        logic [5:0] got;
        got = {route_match, accept_now, stop_rx, err_inc};
        checks++;
        if (got !== exp_code) begin
            failed++;
            $display("FAIL %s: outputs %b expected %b at %0t", cur_tag, got, exp_code, $time);
        end
        if (got != 6'd0) evt = got;
    endtask

    task automatic drive(input bit v, input bit s, input logic [7:0] d);
        @(negedge clk);
        check_outputs();
        rx_valid = v;
        rx_sof = s;
        rx_data = d;
        if (v && s) begin
            fq.delete();
            in_frame = 1;
        end
        if (v && in_frame) fq.push_back(d);
        exp_code = (v && in_frame) ? ref_eval() : 6'd0;
    endtask

    task automatic send_frame(input logic [7:0] fc, input bit rii, input logic [7:0] rcf0,
                              input logic [7:0] rcf1, input int nrd, input bit gaps, input int cut);
        logic [7:0] b [$];
        int lim;
        evt = 6'd0;
        b.push_back(fc);
        for (int i = 1; i <= 6; i++) b.push_back(8'h10 + 8'(i));
        b.push_back({rii, 7'h22});
        for (int i = 8; i <= 12; i++) b.push_back(8'h30 + 8'(i));
        b.push_back(rcf0);
        b.push_back(rcf1);
        for (int i = 0; i < nrd; i++) begin
            b.push_back(rd_ring[i][11:4]);
            b.push_back({rd_ring[i][3:0], rd_br[i]});
        end
        lim = (cut > 0 && cut < b.size()) ? cut : b.size();
        for (int i = 0; i < lim; i++) begin
            drive(1'b1, i == 0, b[i]);
            if (gaps && (i % 3 == 1)) drive(1'b0, 1'b0, 8'h00);
        end
        if (cut == 0) begin
            drive(1'b0, 1'b0, 8'h00);
            drive(1'b0, 1'b0, 8'h00);
        end
    endtask

    task automatic frame_expect(input string tag, input logic [5:0] code);
        checks++;
        if (evt !== code) begin
            failed++;
            $display("FAIL %s: frame pulse %b expected %b", tag, evt, code);
        end
    endtask

    task automatic set2(input logic [11:0] r0, input logic [3:0] b0, input logic [11:0] r1, input logic [3:0] b1);
        rd_ring[0] = r0; rd_br[0] = b0; rd_ring[1] = r1; rd_br[1] = b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failed++;
        $display("FAIL R10: watchdog expired, actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", checks, failed);
        $finish;
    end

    initial begin
        for (int e = 0; e < NE; e++) begin
            tin[e] = 12'h100 + 12'(e);
            tbn[e] = 4'(e);
            tout[e] = 12'h200 + 12'(e);
        end
        en = 16'h7FFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_tag = "R10";
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00);

        // R1 tokens are ignored
        cur_tag = "R1";
        set2(12'h103, 4'd3, 12'h203, 4'd0);
        send_frame(8'h80, 1'b1, {3'b000, 5'd6}, 8'h00, 2, 0, 0);
        frame_expect("R1", 6'b000000);
        send_frame(8'hC0, 1'b1, {3'b000, 5'd6}, 8'h00, 2, 0, 0);
        frame_expect("R1", 6'b000000);

        // R2 indicator low
        cur_tag = "R2";
        send_frame(8'h40, 1'b0, {3'b000, 5'd6}, 8'h00, 2, 0, 0);
        frame_expect("R2", 6'b000000);

        // R8 forward hop matches entry 3
        cur_tag = "R8";
        send_frame(8'h40, 1'b1, {3'b000, 5'd6}, 8'h00, 2, 0, 0);
        frame_expect("R8", 6'b100000);

        // R6 reversed direction
        cur_tag = "R6";
        set2(12'h203, 4'd3, 12'h103, 4'd0);
        send_frame(8'h40, 1'b1, {3'b000, 5'd6}, 8'h80, 2, 0, 0);
        frame_expect("R6", 6'b100000);
        send_frame(8'h40, 1'b1, {3'b000, 5'd6}, 8'h00, 2, 0, 0);
        frame_expect("R6", 6'b001001);

        // R7 disabled entry and bridge mismatch
        cur_tag = "R7";
        set2(12'h10F, 4'd15, 12'h20F, 4'd0);
        send_frame(8'h40, 1'b1, {3'b000, 5'd6}, 8'h00, 2, 0, 0);
        frame_expect("R7", 6'b001001);
        set2(12'h103, 4'd4, 12'h203, 4'd0);
        send_frame(8'h40, 1'b1, {3'b000, 5'd6}, 8'h00, 2, 1, 0);
        frame_expect("R7", 6'b001001);
        rd_ring[0] = 12'h050; rd_br[0] = 4'd1;
        rd_ring[1] = 12'h104; rd_br[1] = 4'd4;
        rd_ring[2] = 12'h204; rd_br[2] = 4'd2;
        rd_ring[3] = 12'h060; rd_br[3] = 4'd0;
        send_frame(8'h40, 1'b1, {3'b000, 5'd10}, 8'h00, 4, 1, 0);
        frame_expect("R7", 6'b100000);

        // R5 length rejects
        cur_tag = "R5";
        send_frame(8'h40, 1'b1, {3'b000, 5'd0}, 8'h00, 2, 0, 0);
        frame_expect("R5", 6'b001001);
        send_frame(8'h40, 1'b1, {3'b000, 5'd7}, 8'h00, 2, 0, 0);
        frame_expect("R5", 6'b001001);
        send_frame(8'h40, 1'b1, {3'b000, 5'd20}, 8'h00, 2, 0, 0);
        frame_expect("R5", 6'b001001);
        send_frame(8'h40, 1'b1, {3'b100, 5'd0}, 8'h00, 2, 0, 0);
        frame_expect("R5", 6'b001010);

        // R9 explorer loop check and empty routes
        cur_tag = "R9";
        send_frame(8'h40, 1'b1, {3'b000, 5'd2}, 8'h00, 0, 0, 0);
        frame_expect("R9", 6'b001001);
        send_frame(8'h40, 1'b1, {3'b100, 5'd2}, 8'h00, 0, 0, 0);
        frame_expect("R9", 6'b100000);
        set2(12'h050, 4'd1, 12'h060, 4'd0);
        send_frame(8'h40, 1'b1, {3'b100, 5'd6}, 8'h00, 2, 0, 0);
        frame_expect("R9", 6'b100000);
        set2(12'h050, 4'd1, 12'h0A1, 4'd0);
        send_frame(8'h40, 1'b1, {3'b101, 5'd6}, 8'h00, 2, 0, 0);
        frame_expect("R9", 6'b001010);

        // R4 per-type actions
        cur_tag = "R4";
        send_frame(8'h40, 1'b1, {3'b110, 5'd6}, 8'h00, 2, 0, 0);
        frame_expect("R4", 6'b010000);
        sel = 6'b010100;
        send_frame(8'h40, 1'b1, {3'b000, 5'd6}, 8'h00, 2, 0, 0);
        frame_expect("R4", 6'b001000);
        send_frame(8'h40, 1'b1, {3'b110, 5'd6}, 8'h00, 2, 0, 0);
        frame_expect("R4", 6'b001100);
        sel = 6'b010111;
        send_frame(8'h40, 1'b1, {3'b000, 5'd6}, 8'h00, 2, 0, 0);
        frame_expect("R4", 6'b001000);

        // R3 type decoding across all routing-type codes
        cur_tag = "R3";
        sel = 6'b010010;
        send_frame(8'h40, 1'b1, {3'b011, 5'd2}, 8'h00, 0, 0, 0);
        frame_expect("R3", 6'b010000);
        send_frame(8'h40, 1'b1, {3'b101, 5'd2}, 8'h00, 0, 0, 0);
        frame_expect("R3", 6'b001000);
        send_frame(8'h40, 1'b1, {3'b111, 5'd2}, 8'h00, 0, 0, 0);
        frame_expect("R3", 6'b100000);

        // R11 restart in the middle of a frame
        cur_tag = "R11";
        sel = 6'b100101;
        set2(12'h103, 4'd3, 12'h203, 4'd0);
        send_frame(8'h40, 1'b1, {3'b000, 5'd6}, 8'h00, 2, 0, 16);
        frame_expect("R11", 6'b000000);
        send_frame(8'h40, 1'b1, {3'b000, 5'd6}, 8'h00, 2, 0, 0);
        frame_expect("R11", 6'b100000);

        // Longest route with maximum length allowed
        cur_tag = "R8";
        maxlen = 5'd30;
        for (int i = 0; i < 14; i++) begin
            rd_ring[i] = 12'h300 + 12'(i);
            rd_br[i] = 4'(i);
        end
        rd_ring[12] = 12'h10C; rd_br[12] = 4'd12; rd_ring[13] = 12'h20C;
        send_frame(8'h40, 1'b1, {3'b000, 5'd30}, 8'h00, 14, 0, 0);
        frame_expect("R8", 6'b100000);

        // Randomized frames checked against the model on every clock
        cur_tag = "R10";
        for (int f = 0; f < 400; f++) begin
            int nrd, lth, k;
            logic [2:0] rt;
            sel = 6'($urandom);
            maxlen = (f % 4 == 0) ? 5'($urandom) : 5'd30;
            lth = ($urandom % 8 == 0) ? int'($urandom % 32) : 2 + 2 * int'($urandom % 15);
            nrd = (lth >= 2) ? (lth - 2) / 2 : 0;
            rt = 3'($urandom);
            for (int i = 0; i < 16; i++) begin
                k = int'($urandom % 16);
                case ($urandom % 4)
                    0: rd_ring[i] = tin[k];
                    1: rd_ring[i] = tout[k];
                    2: rd_ring[i] = port_ring;
                    default: rd_ring[i] = 12'($urandom);
                endcase
                rd_br[i] = ($urandom % 2 == 0) ? 4'(k) : 4'($urandom);
            end
            send_frame(($urandom % 8 == 0) ? 8'hC0 : 8'h40, ($urandom % 6) != 0,
                       {rt, 5'(lth)}, {1'($urandom), 7'h00}, nrd, ($urandom % 3) == 0, 0);
        end

        drive(1'b0, 1'b0, 8'h00);
        $display("  [TB] %0d tests run, %0d failed", checks, failed);
        $finish;
    end
endmodule